// File: doc/BRIEF.md
# NAND Flash Single-Cycle Strobe Bridge

This block connects a simple internal request/response host bus to one or more external NAND flash devices. Each host access to the flash window becomes exactly one asynchronous strobe cycle on the flash pins. Software builds a complete flash operation out of a series of these cycles: first a command cycle, then one or more address cycles, then the data cycles.

The kind of cycle is chosen by the host address rather than by a mode register. Host address bit 12 drives the command-latch output, and bit 11 drives the address-latch output. When neither bit is set, the cycle is a plain data cycle. Every cycle walks through three counted phases. In the setup phase the chip enable is low and the latch lines are steady. In the strobe phase write enable or read enable is low. In the hold phase the chip enable stays low while both strobes are high.

Each chip select has its own setup, strobe and hold counts. Each also has its own flag that selects NAND behaviour or plain asynchronous memory behaviour, and its own flag for an 8-bit or 16-bit device. The flash ready/busy line is synchronised and reported in a status register. A sticky flag in that register records the device becoming ready.

Top module: `nand_cycle_bridge`

## Requirements
- R1: A flash-window request is accepted when hostReq is high while hostReady is high. hostReady then stays low for exactly setup+strobe+hold+3 cycles, and a request that arrives during this time waits until hostReady returns high.
- R2: Each flash cycle runs in a fixed order. First, setup+1 cycles with only the selected chip enable low. Next, strobe+1 cycles with fWeN (writes) or fReN (reads) low. Last, hold+1 cycles with the chip enable low and both strobes high.
- R3: For a NAND-mode chip select, fCle equals host address bit 12 and fAle equals host address bit 11 for the whole cycle. A cycle with neither bit set is a data cycle, and both latch lines stay low during it.
- R4: For a chip select in plain mode, fCle and fAle stay low whatever the values of address bits 11 and 12. fAddr carries host address bits 10:0 for the cycle.
- R5: On an 8-bit chip select, a write drives hostWdata[7:0] on fDataOut[7:0] and zeros on fDataOut[15:8]. A read returns fDataIn[7:0] zero-extended to 16 bits.
- R6: On a 16-bit chip select, a write drives all 16 bits of hostWdata. A read returns all 16 bits of fDataIn.
- R7: Read data is sampled at the clock edge that ends the strobe phase. hostRvalid is high for one cycle, the first hold cycle, with that data on hostRdata.
- R8: Status register bit 0 reports fRdyBusy after a two-flop synchroniser. Its reset value is 1 (ready).
- R9: Status bit 1 is set when the synchronised ready level rises from 0 to 1. It stays set until the host writes the status register. If a set and a clear happen in the same cycle, the set wins.
- R10: Register window accesses (bit 15 of the address = 1; index in bits 3:0) finish without any flash cycle, and hostRvalid follows a read one cycle later. Index 0 is control: bits 3:0 select NAND mode per chip select, and bits 11:8 select 16-bit width. Both reset to 0. Index 1 is status. Index 2+n is the timing of chip select n: setup in bits 3:0, strobe in bits 7:4, hold in bits 11:8. Timing resets to 0x0232.
- R11: At most one chip enable is low at a time, and fWeN and fReN are never low together. After reset all chip enables and strobes are high.
- R12: The timing counts used by a cycle are those of the chip select named in address bits 14:13. Each chip select keeps its own counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostReq | input | 1 | Host request valid |
| hostWr | input | 1 | 1 = write, 0 = read |
| hostAddr | input | 16 | Bit 15 selects registers; flash window: 14:13 chip select, 12 command latch, 11 address latch, 10:0 pin address |
| hostWdata | input | 16 | Host write data |
| hostReady | output | 1 | High when a request can be accepted |
| hostRdata | output | 16 | Read data |
| hostRvalid | output | 1 | One-cycle read data valid pulse |
| fCeN | output | NUM_CS | Active-low chip enables |
| fWeN | output | 1 | Active-low write strobe |
| fReN | output | 1 | Active-low read strobe |
| fCle | output | 1 | Command latch enable |
| fAle | output | 1 | Address latch enable |
| fAddr | output | 11 | Pin address for plain-mode devices |
| fDataOut | output | 16 | Data driven to the flash |
| fDataOe | output | 1 | Data output enable during write cycles |
| fDataIn | input | 16 | Data returned by the flash |
| fRdyBusy | input | 1 | Flash ready (1) / busy (0) |

## Verification
The hardest case to create from the ports is a request that is held stalled. The second request must already be present on the bus while the first strobe cycle is still counting. The bench brings this about by putting a new request on the bus in the cycle right after the first one is accepted. It counts the cycles until hostReady returns, and confirms that the waiting request then produces its own complete cycle. The sticky ready flag needs the busy line to drop and rise around status reads. The bench holds fRdyBusy low long enough to pass the synchroniser, and reads status both before and after clearing the flag.

// File: rtl/nand_bridge_pkg.sv
package nand_bridge_pkg;
  localparam int CNT_W      = 4;
  localparam int DATA_W     = 16;
  localparam int BYTE_W     = 8;
  localparam int ADDR_W     = 16;
  localparam int PIN_ADDR_W = 11;
  localparam int ALE_BIT    = 11;
  localparam int CLE_BIT    = 12;
  localparam int CS_LSB     = 13;
  localparam int REG_BIT    = 15;
  localparam int REG_IDX_W  = 4;
  localparam int REG_CTRL   = 0;
  localparam int REG_STAT   = 1;
  localparam int TIM_BASE   = 2;
  localparam int WIDE_LSB   = 8;

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_STROBE, PH_HOLD} phase_e;

  typedef struct packed {
    logic [CNT_W-1:0] hold;
    logic [CNT_W-1:0] strobe;
    logic [CNT_W-1:0] setup;
  } timing_t;

  localparam timing_t RST_TIMING = '{hold: 4'd2, strobe: 4'd3, setup: 4'd2};

  typedef struct packed {
    logic acceptReg;
    logic acceptFlash;
    logic active;
    logic strobe;
    logic capture;
  } ctrl_strobes_t;
endpackage

// File: rtl/nand_cycle_ctrl.sv
module nand_cycle_ctrl
  import nand_bridge_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          hostReq,
  input  logic          hostIsReg,
  input  timing_t       tim,
  output logic          hostReady,
  output ctrl_strobes_t str
);
  phase_e           phase;
  logic [CNT_W-1:0] cnt;
  logic             idle;
  logic             cntDone;

  assign idle      = (phase == PH_IDLE);
  assign cntDone   = (cnt == '0);
  assign hostReady = idle;

  always_comb begin
    str.acceptReg   = hostReq && idle && hostIsReg;
    str.acceptFlash = hostReq && idle && !hostIsReg;
    str.active      = !idle;
    str.strobe      = (phase == PH_STROBE);
    str.capture     = (phase == PH_STROBE) && cntDone;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else begin
      case (phase)
        PH_IDLE: if (str.acceptFlash) begin
          phase <= PH_SETUP;
          cnt   <= tim.setup;
        end
        PH_SETUP: if (cntDone) begin
          phase <= PH_STROBE;
          cnt   <= tim.strobe;
        end else cnt <= cnt - 1'b1;
        PH_STROBE: if (cntDone) begin
          phase <= PH_HOLD;
          cnt   <= tim.hold;
        end else cnt <= cnt - 1'b1;
        PH_HOLD: if (cntDone) phase <= PH_IDLE;
                 else cnt <= cnt - 1'b1;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R1: an accepted flash request makes the bus busy on the next cycle
  p_accept_busy_r1: assert property (@(posedge clk) disable iff (!rstN)
    (hostReq && hostReady && !hostIsReg) |=> !hostReady);

  // R1: the last hold cycle releases the bus
  p_hold_release_r1: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_HOLD && cntDone) |=> hostReady);

  // R2: strobe is only entered from setup
  p_strobe_order_r2: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_STROBE) |-> ($past(phase) == PH_SETUP || $past(phase) == PH_STROBE));
endmodule

// File: rtl/nand_cycle_datapath.sv
module nand_cycle_datapath
  import nand_bridge_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int CS_W   = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrl_strobes_t         str,
  input  logic                  hostWr,
  input  logic [ADDR_W-1:0]     hostAddr,
  input  logic [DATA_W-1:0]     hostWdata,
  output logic                  hostIsReg,
  output logic [DATA_W-1:0]     hostRdata,
  output logic                  hostRvalid,
  output timing_t               tim,
  output logic [NUM_CS-1:0]     fCeN,
  output logic                  fWeN,
  output logic                  fReN,
  output logic                  fCle,
  output logic                  fAle,
  output logic [PIN_ADDR_W-1:0] fAddr,
  output logic [DATA_W-1:0]     fDataOut,
  output logic                  fDataOe,
  input  logic [DATA_W-1:0]     fDataIn,
  input  logic                  fRdyBusy
);
  localparam int HI_W = DATA_W - BYTE_W;

  logic [REG_IDX_W-1:0] regIdx;
  logic [CS_W-1:0]      reqCs;
  logic                 regWrite;
  logic [NUM_CS-1:0]    useNand;
  logic [NUM_CS-1:0]    wide16;
  timing_t [NUM_CS-1:0] timAll;
  logic                 rbMeta, rbSync, rbPrev, readyRise;
  logic [DATA_W-1:0]    regRead;
  logic [CS_W-1:0]      latCs;
  logic                 latWr, latCle, latAle, latNand, latWide;
  logic [PIN_ADDR_W-1:0] latAddr;
  logic [DATA_W-1:0]    latWdata;
  logic [NUM_CS-1:0]    ceOneHot;

  assign hostIsReg = hostAddr[REG_BIT];
  assign regIdx    = hostAddr[REG_IDX_W-1:0];
  assign reqCs     = hostAddr[CS_LSB +: CS_W];
  assign regWrite  = str.acceptReg && hostWr;

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      useNand <= '0;
      wide16  <= '0;
    end else if (regWrite && regIdx == REG_IDX_W'(REG_CTRL)) begin
      useNand <= hostWdata[NUM_CS-1:0];
      wide16  <= hostWdata[WIDE_LSB +: NUM_CS];
    end
  end

  for (genvar g = 0; g < NUM_CS; g++) begin : g_tim
    timing_t timReg;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) timReg <= RST_TIMING;
      else if (regWrite && regIdx == REG_IDX_W'(TIM_BASE + g))
        timReg <= timing_t'(hostWdata[3*CNT_W-1:0]);
    end
    assign timAll[g] = timReg;
  end

  assign tim = str.active ? timAll[latCs] : timAll[reqCs];

  // ready/busy synchroniser and sticky rise flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rbMeta    <= 1'b1;
      rbSync    <= 1'b1;
      rbPrev    <= 1'b1;
      readyRise <= 1'b0;
    end else begin
      rbMeta <= fRdyBusy;
      rbSync <= rbMeta;
      rbPrev <= rbSync;
      if (rbSync && !rbPrev) readyRise <= 1'b1;
      else if (regWrite && regIdx == REG_IDX_W'(REG_STAT)) readyRise <= 1'b0;
    end
  end

  always_comb begin
    regRead = '0;
    if (regIdx == REG_IDX_W'(REG_CTRL)) begin
      regRead[NUM_CS-1:0]          = useNand;
      regRead[WIDE_LSB +: NUM_CS]  = wide16;
    end else if (regIdx == REG_IDX_W'(REG_STAT)) begin
      regRead[1:0] = {readyRise, rbSync};
    end else begin
      for (int i = 0; i < NUM_CS; i++)
        if (regIdx == REG_IDX_W'(TIM_BASE + i)) regRead[3*CNT_W-1:0] = timAll[i];
    end
  end

  // per-cycle request latch
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latCs    <= '0;
      latWr    <= 1'b0;
      latCle   <= 1'b0;
      latAle   <= 1'b0;
      latNand  <= 1'b0;
      latWide  <= 1'b0;
      latAddr  <= '0;
      latWdata <= '0;
    end else if (str.acceptFlash) begin
      latCs    <= reqCs;
      latWr    <= hostWr;
      latCle   <= hostAddr[CLE_BIT];
      latAle   <= hostAddr[ALE_BIT];
      latNand  <= useNand[reqCs];
      latWide  <= wide16[reqCs];
      latAddr  <= hostAddr[PIN_ADDR_W-1:0];
      latWdata <= hostWdata;
    end
  end

  // read return
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hostRvalid <= 1'b0;
      hostRdata  <= '0;
    end else begin
      hostRvalid <= 1'b0;
      if (str.acceptReg && !hostWr) begin
        hostRvalid <= 1'b1;
        hostRdata  <= regRead;
      end else if (str.capture && !latWr) begin
        hostRvalid <= 1'b1;
        hostRdata  <= latWide ? fDataIn : {{HI_W{1'b0}}, fDataIn[BYTE_W-1:0]};
      end
    end
  end

  // flash pins
  always_comb begin
    ceOneHot = '0;
    if (str.active) ceOneHot[latCs] = 1'b1;
  end

  assign fCeN     = ~ceOneHot;
  assign fCle     = str.active && latNand && latCle;
  assign fAle     = str.active && latNand && latAle;
  assign fWeN     = !(str.strobe && latWr);
  assign fReN     = !(str.strobe && !latWr);
  assign fDataOe  = str.active && latWr;
  assign fDataOut = latWide ? latWdata : {{HI_W{1'b0}}, latWdata[BYTE_W-1:0]};
  assign fAddr    = latAddr;

  // R11: never two chips enabled at once
  p_one_ce_r11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~fCeN));

  // R3: latch lines do not move inside a cycle
  p_latch_stable_r3: assert property (@(posedge clk) disable iff (!rstN)
    (str.active && $past(str.active)) |-> ($stable(fCle) && $stable(fAle)));

  // R9: a synchronised rise always leaves the sticky flag set
  p_sticky_set_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rbSync && !rbPrev) |=> readyRise);
endmodule

// File: rtl/nand_cycle_bridge.sv
module nand_cycle_bridge
  import nand_bridge_pkg::*;
#(
  parameter int NUM_CS = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  hostReq,
  input  logic                  hostWr,
  input  logic [ADDR_W-1:0]     hostAddr,
  input  logic [DATA_W-1:0]     hostWdata,
  output logic                  hostReady,
  output logic [DATA_W-1:0]     hostRdata,
  output logic                  hostRvalid,
  output logic [NUM_CS-1:0]     fCeN,
  output logic                  fWeN,
  output logic                  fReN,
  output logic                  fCle,
  output logic                  fAle,
  output logic [PIN_ADDR_W-1:0] fAddr,
  output logic [DATA_W-1:0]     fDataOut,
  output logic                  fDataOe,
  input  logic [DATA_W-1:0]     fDataIn,
  input  logic                  fRdyBusy
);
  localparam int CS_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;

  ctrl_strobes_t str;
  timing_t       tim;
  logic          hostIsReg;

  nand_cycle_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .hostReq   (hostReq),
    .hostIsReg (hostIsReg),
    .tim       (tim),
    .hostReady (hostReady),
    .str       (str)
  );

  nand_cycle_datapath #(.NUM_CS(NUM_CS), .CS_W(CS_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .str        (str),
    .hostWr     (hostWr),
    .hostAddr   (hostAddr),
    .hostWdata  (hostWdata),
    .hostIsReg  (hostIsReg),
    .hostRdata  (hostRdata),
    .hostRvalid (hostRvalid),
    .tim        (tim),
    .fCeN       (fCeN),
    .fWeN       (fWeN),
    .fReN       (fReN),
    .fCle       (fCle),
    .fAle       (fAle),
    .fAddr      (fAddr),
    .fDataOut   (fDataOut),
    .fDataOe    (fDataOe),
    .fDataIn    (fDataIn),
    .fRdyBusy   (fRdyBusy)
  );
endmodule

// File: tb/sim_nand_cycle_bridge.sv
`timescale 1ns/1ps
module sim_nand_cycle_bridge;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostReq = 1'b0, hostWr = 1'b0;
  logic [15:0] hostAddr = '0, hostWdata = '0;
  logic        hostReady, hostRvalid;
  logic [15:0] hostRdata;
  logic [3:0]  fCeN;
  logic        fWeN, fReN, fCle, fAle, fDataOe;
  logic [10:0] fAddr;
  logic [15:0] fDataOut, fDataIn;
  logic        fRdyBusy = 1'b1;
  logic [15:0] rdModel = 16'h0000;

  always #4 clk = ~clk;
  assign fDataIn = fReN ? 16'h0000 : rdModel;

  nand_cycle_bridge u0 (
    .clk(clk), .rstN(rstN), .hostReq(hostReq), .hostWr(hostWr), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .hostReady(hostReady), .hostRdata(hostRdata), .hostRvalid(hostRvalid),
    .fCeN(fCeN), .fWeN(fWeN), .fReN(fReN), .fCle(fCle), .fAle(fAle), .fAddr(fAddr),
    .fDataOut(fDataOut), .fDataOe(fDataOe), .fDataIn(fDataIn), .fRdyBusy(fRdyBusy)
  );

  int tests = 0, fails = 0, cycles = 0;
  int tS[4], tT[4], tH[4];
  bit nandB[4], wideB[4];

  // expected flash-side events
  int          qCs[$], qSet[$], qStb[$], qHld[$];
  bit          qCle[$], qAle[$], qWr[$];
  logic [15:0] qData[$];
  logic [10:0] qAddr[$];
  string       qTag[$];
  // expected host read returns
  logic [15:0] rdQ[$];
  string       rdTag[$];

  task automatic check(input bit ok, input string msg);
    tests++;
    if (!ok) begin fails++; $display("FAIL %s", msg); end
  endtask

  // monitor: host read returns
  always @(negedge clk) begin
    if (rstN && hostRvalid) begin
      if (rdQ.size() == 0) check(1'b0, $sformatf("R10 unexpected read data %h exp none", hostRdata));
      else begin
        logic [15:0] e;
        string tg;
        e = rdQ.pop_front(); tg = rdTag.pop_front();
        check(hostRdata == e, $sformatf("%s read data act=%h exp=%h", tg, hostRdata, e));
      end
    end
  end

  // monitor: flash-side cycles
  bit inCyc = 0;
  int setN, stbN, hldN, curCs;
  bit seenCle, seenAle, seenWr, seenOe;
  logic [15:0] seenData;
  logic [10:0] seenAddr;
  always @(negedge clk) begin
    if (rstN) begin
      check(!(!fWeN && !fReN), "R11 both strobes low act=1 exp=0");
      if (fCeN != 4'hF) begin
        if (!inCyc) begin
          inCyc = 1; setN = 0; stbN = 0; hldN = 0; curCs = 0;
          for (int i = 0; i < 4; i++) if (!fCeN[i]) curCs = i;
        end
        if (!fWeN || !fReN) begin
          stbN++; seenCle = fCle; seenAle = fAle; seenWr = !fWeN;
          seenData = fDataOut; seenAddr = fAddr; seenOe = fDataOe;
        end else if (stbN == 0) setN++;
        else hldN++;
      end else if (inCyc) begin
        inCyc = 0;
        if (qCs.size() == 0) check(1'b0, "R10 unexpected flash cycle act=1 exp=0");
        else begin
          int eCs, eS, eT, eH; bit eCle, eAle, eWr; logic [15:0] eD; logic [10:0] eA; string tg; bit ok;
          eCs = qCs.pop_front(); eS = qSet.pop_front(); eT = qStb.pop_front(); eH = qHld.pop_front();
          eCle = qCle.pop_front(); eAle = qAle.pop_front(); eWr = qWr.pop_front();
          eD = qData.pop_front(); eA = qAddr.pop_front(); tg = qTag.pop_front();
          ok = (curCs == eCs) && (seenCle == eCle) && (seenAle == eAle) && (seenWr == eWr) &&
               (seenAddr == eA) && (seenOe == eWr) && (!eWr || seenData == eD);
          check(ok, $sformatf("%s pins act cs=%0d cle=%b ale=%b wr=%b addr=%h d=%h exp cs=%0d cle=%b ale=%b wr=%b addr=%h d=%h",
                tg, curCs, seenCle, seenAle, seenWr, seenAddr, seenData, eCs, eCle, eAle, eWr, eA, eD));
          check(setN == eS && stbN == eT && hldN == eH,
                $sformatf("R2 %s phases act=%0d/%0d/%0d exp=%0d/%0d/%0d", tg, setN, stbN, hldN, eS, eT, eH));
        end
      end
    end
  end

  task automatic hostAccess(input bit wr, input logic [15:0] addr, input logic [15:0] wd, output int busy);
    @(negedge clk);
    hostReq = 1; hostWr = wr; hostAddr = addr; hostWdata = wd;
    while (!hostReady) @(negedge clk);
    @(negedge clk);
    hostReq = 0; busy = 0;
    while (!hostReady) begin busy++; @(negedge clk); end
  endtask

  task automatic regWrite(input int idx, input logic [15:0] v);
    int b;
    hostAccess(1'b1, 16'h8000 | 16'(idx), v, b);
    check(b == 0, $sformatf("R10 register write busy act=%0d exp=0", b));
  endtask

  task automatic regRead(input int idx, input logic [15:0] e, input string tg);
    int b;
    rdQ.push_back(e); rdTag.push_back(tg);
    hostAccess(1'b0, 16'h8000 | 16'(idx), 16'h0, b);
    @(negedge clk);
  endtask

  // kind: 0 data, 1 command, 2 address
  task automatic pushFlash(input int cs, input int kind, input bit wr, input logic [10:0] low,
                           input logic [15:0] d, input string tg, output logic [15:0] addr);
    addr = {1'b0, 2'(cs), kind == 1, kind == 2, low};
    qCs.push_back(cs); qSet.push_back(tS[cs] + 1); qStb.push_back(tT[cs] + 1); qHld.push_back(tH[cs] + 1);
    qCle.push_back(nandB[cs] && kind == 1); qAle.push_back(nandB[cs] && kind == 2); qWr.push_back(wr);
    qData.push_back(wideB[cs] ? d : {8'h00, d[7:0]}); qAddr.push_back(low); qTag.push_back(tg);
    if (!wr) begin
      rdQ.push_back(wideB[cs] ? rdModel : {8'h00, rdModel[7:0]}); rdTag.push_back(tg);
    end
  endtask

  task automatic flashOp(input int cs, input int kind, input bit wr, input logic [10:0] low,
                         input logic [15:0] d, input string tg);
    logic [15:0] a; int b, e;
    pushFlash(cs, kind, wr, low, d, tg, a);
    hostAccess(wr, a, d, b);
    e = tS[cs] + tT[cs] + tH[cs] + 3;
    check(b == e, $sformatf("R1 %s busy act=%0d exp=%0d", tg, b, e));
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin tS[i] = 2; tT[i] = 3; tH[i] = 2; nandB[i] = 0; wideB[i] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check(hostReady && fCeN == 4'hF && fWeN && fReN && !fCle && !fAle,
          $sformatf("R11 reset pins act rdy=%b ce=%h we=%b re=%b exp 1 f 1 1", hostReady, fCeN, fWeN, fReN));
    regRead(0, 16'h0000, "R10 control reset");
    regRead(5, 16'h0232, "R10 timing reset");
    regRead(1, 16'h0001, "R8 status reset");

    // cs0 NAND 8-bit, cs1 NAND 16-bit, cs2 plain 16-bit
    regWrite(0, 16'h0603);
    nandB[0] = 1; nandB[1] = 1; wideB[1] = 1; wideB[2] = 1;
    regWrite(2, 16'h0021); tS[0] = 1; tT[0] = 2; tH[0] = 0;
    regWrite(3, 16'h0300); tS[1] = 0; tT[1] = 0; tH[1] = 3;
    regWrite(4, 16'h0113); tS[2] = 3; tT[2] = 1; tH[2] = 1;
    regRead(0, 16'h0603, "R10 control readback");
    regRead(2, 16'h0021, "R10 timing cs0 readback");
    regRead(4, 16'h0113, "R10 timing cs2 readback");

    flashOp(0, 1, 1, 11'h000, 16'h1234, "R3 R5 cs0 command");
    flashOp(0, 2, 1, 11'h000, 16'h00A5, "R3 cs0 address");
    flashOp(0, 2, 1, 11'h000, 16'h003C, "R3 cs0 address 2");
    rdModel = 16'hABCD;
    flashOp(0, 0, 0, 11'h000, 16'h0000, "R3 R5 R7 cs0 data read");
    flashOp(0, 0, 1, 11'h000, 16'hFF11, "R5 cs0 data write");
    flashOp(1, 1, 1, 11'h000, 16'hBEEF, "R6 R12 cs1 command");
    rdModel = 16'h5A5A;
    flashOp(1, 0, 0, 11'h000, 16'h0000, "R6 R7 R12 cs1 data read");
    flashOp(2, 1, 1, 11'h155, 16'h7777, "R4 cs2 plain write");
    rdModel = 16'hC3E1;
    flashOp(2, 2, 0, 11'h2AA, 16'h0000, "R4 cs2 plain read");

    // stalled back-to-back request
    begin
      logic [15:0] a1, a2; int st;
      pushFlash(1, 0, 1, 11'h000, 16'h0F0F, "R1 stall first", a1);
      rdModel = 16'h9876;
      pushFlash(0, 0, 0, 11'h000, 16'h0000, "R1 stall second", a2);
      @(negedge clk);
      hostReq = 1; hostWr = 1; hostAddr = a1; hostWdata = 16'h0F0F;
      while (!hostReady) @(negedge clk);
      @(negedge clk);
      hostWr = 0; hostAddr = a2; hostWdata = 16'h0; st = 0;
      while (!hostReady) begin st++; @(negedge clk); end
      check(st == tS[1] + tT[1] + tH[1] + 3, $sformatf("R1 stall length act=%0d exp=%0d", st, tS[1] + tT[1] + tH[1] + 3));
      @(negedge clk);
      hostReq = 0;
      while (!hostReady) @(negedge clk);
      repeat (2) @(negedge clk);
    end

    // ready/busy status
    fRdyBusy = 0;
    repeat (6) @(negedge clk);
    regRead(1, 16'h0000, "R8 busy level");
    fRdyBusy = 1;
    repeat (6) @(negedge clk);
    regRead(1, 16'h0003, "R8 R9 ready rise sticky");
    regRead(1, 16'h0003, "R9 flag persists");
    regWrite(1, 16'h0000);
    regRead(1, 16'h0001, "R9 flag cleared");

    repeat (4) @(negedge clk);
    check(qCs.size() == 0 && rdQ.size() == 0,
          $sformatf("R10 leftover expectations act=%0d/%0d exp=0/0", qCs.size(), rdQ.size()));
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      tests++; fails++;
      $display("FAIL watchdog act=%0d cycles exp=done", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule